// File: doc/BRIEF.md
# Clock-Generator Configuration Register Slave

This block is the serial configuration port of an on-chip clock generator. It watches a two-wire bus (SCL, SDA) from the system clock domain, recognises start and stop conditions, and answers to one fixed 7-bit device address. A controller writing to it sends the address, then two filler bytes (a command byte and a count byte) whose values do not matter, and then a stream of data bytes. The stream fills the configuration registers strictly in sequence from register 0 upward; there is no register-address pointer.

The registers drive the rest of the clock generator directly. Register 0 carries the frequency-select code. Every following register holds eight output-enable bits, one per clock output, so each output can be switched on or off on its own. With the read direction bit set, the slave shifts the latched register values back out, again starting at register 0, so software can confirm what it wrote.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: After reset, with default parameters, `freqSel` reads 4'h3, `clkEn` reads all ones (24'hFFFFFF) and `sdaOe` is 0.
- R2: The slave acknowledges (holds SDA low during the ninth SCL pulse) an address byte of 8'hD2 (address 7'h69, write). With any other address it acknowledges nothing and changes no register until the next start condition.
- R3: The first two bytes after a matched write address are acknowledged and change no register.
- R4: Data bytes, received MSB first, are stored into register 0, 1, 2, 3 in that order and each is acknowledged.
- R5: Data bytes beyond the last register are acknowledged and discarded.
- R6: A stop condition ends the transaction at any point: a partially received byte is not stored, and bytes clocked afterwards without a new start are neither acknowledged nor stored.
- R7: After address byte 8'hD3 (read) is acknowledged, the slave shifts out register 0, 1, 2, 3 MSB first, one per controller acknowledge, then 8'hFF past the last register; after the controller's no-acknowledge it releases SDA.
- R8: The slave changes its SDA drive only while SCL is low.
- R9: `freqSel` equals register 0 bits [3:0]; `clkEn` bit 8*(k-1)+j equals bit j of register k for k = 1..3.
- R10: A repeated start restarts the sequence: the next byte is an address and the data stream begins again at register 0 after two new filler bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line as seen on the bus |
| sdaIn | input | 1 | Serial data line as seen on the bus |
| sdaOe | output | 1 | When 1, the pad pulls SDA low (open drain) |
| freqSel | output | 4 | Frequency-select code from register 0 |
| clkEn | output | 24 | Per-output clock enables from registers 1 to 3 |

## Verification
The assertions take for granted a well-behaved bus controller: SDA changes only while SCL is low except for start and stop, every SCL high and low phase lasts longer than the synchronizer and edge-detector delay, and no start or stop is issued while the slave itself is pulling SDA low. The stimulus keeps within this by holding each SCL half period for ten system clocks, moving SDA at the middle of the low phase, and lowering SCL before any byte that is clocked without a start. Random transactions vary address, byte count and data, while directed cases cover a stop in the middle of a byte, orphan bytes after a stop, a repeated start and reads past the last register.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXEND,
    ST_ACK,
    ST_TX,
    ST_TXACK,
    ST_TXNEXT,
    ST_WAIT
  } ctrlState_t;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic shiftIn;   // shift bitVal into the receive register
    logic bitVal;    // sampled SDA level
    logic writeReg;  // store received byte into the indexed register
    logic loadTx;    // load the transmit shifter from the indexed register
    logic shiftTx;   // advance the transmit shifter by one bit
  } dpStrobe_t;

endpackage

// File: rtl/clkcfg_sync.sv
module clkcfg_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stg <= '1;
    end else begin
      stg[0] <= din;
      for (int s = 1; s < STAGES; s++) begin
        stg[s] <= stg[s-1];
      end
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/clkcfg_i2c_ctrl.sv
module clkcfg_i2c_ctrl
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NUM_REGS    = 4,
  parameter int         SYNC_STAGES = 2,
  parameter int         PTR_W       = $clog2(NUM_REGS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic [7:0]       rxByte,
  input  logic             txBit,
  output dpStrobe_t        strb,
  output logic [PTR_W-1:0] regIdx,
  output logic             sdaOe
);

  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NUM_REGS);
  localparam logic [1:0]       PH_DATA = 2'd3;

  logic [1:0] lineS;
  logic sclS, sdaS, sclD, sdaD;
  logic sclRise, sclFall, startSeen, stopSeen;

  clkcfg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({sclIn, sdaIn}),
    .dout(lineS)
  );

  assign sclS = lineS[1];
  assign sdaS = lineS[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  assign sclRise   = sclS & ~sclD;
  assign sclFall   = ~sclS & sclD;
  assign startSeen = sclS & sclD & sdaD & ~sdaS;
  assign stopSeen  = sclS & sclD & ~sdaD & sdaS;

  ctrlState_t       state, stateN;
  logic [2:0]       bitCnt, bitCntN;
  logic [1:0]       phase, phaseN;
  logic [PTR_W-1:0] ptr, ptrN;
  logic             readMode, readModeN;

  always_comb begin
    stateN       = state;
    bitCntN      = bitCnt;
    phaseN       = phase;
    ptrN         = ptr;
    readModeN    = readMode;
    strb         = '0;
    strb.bitVal  = sdaS;
    if (stopSeen) begin
      stateN = ST_IDLE;
    end else if (startSeen) begin
      stateN    = ST_RX;
      bitCntN   = 3'd0;
      phaseN    = 2'd0;
      ptrN      = '0;
      readModeN = 1'b0;
    end else begin
      unique case (state)
        ST_RX: if (sclRise) begin
          strb.shiftIn = 1'b1;
          if (bitCnt == 3'd7) stateN = ST_RXEND;
          else                bitCntN = bitCnt + 3'd1;
        end
        ST_RXEND: if (sclFall) begin
          if (phase == 2'd0) begin
            if (rxByte[7:1] == DEV_ADDR) begin
              stateN    = ST_ACK;
              readModeN = rxByte[0];
            end else begin
              stateN = ST_WAIT;
            end
          end else begin
            stateN = ST_ACK;
            if (phase == PH_DATA && ptr != PTR_END) strb.writeReg = 1'b1;
          end
        end
        ST_ACK: if (sclFall) begin
          bitCntN = 3'd0;
          if (phase != PH_DATA)    phaseN = phase + 2'd1;
          else if (ptr != PTR_END) ptrN   = ptr + PTR_W'(1);
          if (readMode) begin
            stateN      = ST_TX;
            strb.loadTx = 1'b1;
          end else begin
            stateN = ST_RX;
          end
        end
        ST_TX: if (sclFall) begin
          if (bitCnt == 3'd7) begin
            stateN = ST_TXACK;
          end else begin
            bitCntN      = bitCnt + 3'd1;
            strb.shiftTx = 1'b1;
          end
        end
        ST_TXACK: if (sclRise) begin
          stateN = sdaS ? ST_WAIT : ST_TXNEXT;
        end
        ST_TXNEXT: if (sclFall) begin
          bitCntN     = 3'd0;
          if (ptr != PTR_END) ptrN = ptr + PTR_W'(1);
          strb.loadTx = 1'b1;
          stateN      = ST_TX;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= 3'd0;
      phase    <= 2'd0;
      ptr      <= '0;
      readMode <= 1'b0;
    end else begin
      state    <= stateN;
      bitCnt   <= bitCntN;
      phase    <= phaseN;
      ptr      <= ptrN;
      readMode <= readModeN;
    end
  end

  assign regIdx = ptrN;
  assign sdaOe  = (state == ST_ACK) | ((state == ST_TX) & ~txBit);

  // R8
  sda_change_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclS);

  // R6
  stop_goes_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> (state == ST_IDLE) && !sdaOe);

  // R7
  tx_only_in_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TX) |-> readMode);

endmodule

// File: rtl/clkcfg_i2c_data.sv
module clkcfg_i2c_data
  import clkcfg_pkg::*;
#(
  parameter int                        NUM_REGS     = 4,
  parameter int                        PTR_W        = $clog2(NUM_REGS + 1),
  parameter logic [NUM_REGS*8-1:0]     REG_DEFAULTS = '1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strb,
  input  logic [PTR_W-1:0]      regIdx,
  output logic [7:0]            rxByte,
  output logic                  txBit,
  output logic [NUM_REGS*8-1:0] regsFlat
);

  logic [7:0]                rxShift, txShift, readSel;
  logic [NUM_REGS-1:0][7:0]  regs;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rxShift <= 8'h00;
    else if (strb.shiftIn) rxShift <= {rxShift[6:0], strb.bitVal};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regs <= REG_DEFAULTS;
    end else if (strb.writeReg) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (regIdx == PTR_W'(i)) regs[i] <= rxShift;
      end
    end
  end

  always_comb begin
    readSel = 8'hFF;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (regIdx == PTR_W'(i)) readSel = regs[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             txShift <= 8'hFF;
    else if (strb.loadTx)  txShift <= readSel;
    else if (strb.shiftTx) txShift <= {txShift[6:0], 1'b1};
  end

  assign rxByte   = rxShift;
  assign txBit    = txShift[7];
  assign regsFlat = regs;

  // R5
  write_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeReg |-> (regIdx < PTR_W'(NUM_REGS)));

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_regChk
      // R3
      reg_changes_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
        !$stable(regs[g]) |-> $past(strb.writeReg));
    end
  endgenerate

endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave
  import clkcfg_pkg::*;
#(
  parameter logic [6:0]            DEV_ADDR     = 7'h69,
  parameter int                    NUM_REGS     = 4,
  parameter int                    FSEL_W       = 4,
  parameter int                    SYNC_STAGES  = 2,
  parameter logic [NUM_REGS*8-1:0] REG_DEFAULTS = {{(NUM_REGS-1){8'hFF}}, 8'h03}
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sclIn,
  input  logic                        sdaIn,
  output logic                        sdaOe,
  output logic [FSEL_W-1:0]           freqSel,
  output logic [(NUM_REGS-1)*8-1:0]   clkEn
);

  localparam int PTR_W = $clog2(NUM_REGS + 1);

  dpStrobe_t             strb;
  logic [PTR_W-1:0]      regIdx;
  logic [7:0]            rxByte;
  logic                  txBit;
  logic [NUM_REGS*8-1:0] regsFlat;

  clkcfg_i2c_ctrl #(
    .DEV_ADDR   (DEV_ADDR),
    .NUM_REGS   (NUM_REGS),
    .SYNC_STAGES(SYNC_STAGES),
    .PTR_W      (PTR_W)
  ) i_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .sclIn (sclIn),
    .sdaIn (sdaIn),
    .rxByte(rxByte),
    .txBit (txBit),
    .strb  (strb),
    .regIdx(regIdx),
    .sdaOe (sdaOe)
  );

  clkcfg_i2c_data #(
    .NUM_REGS    (NUM_REGS),
    .PTR_W       (PTR_W),
    .REG_DEFAULTS(REG_DEFAULTS)
  ) i_data (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .regIdx  (regIdx),
    .rxByte  (rxByte),
    .txBit   (txBit),
    .regsFlat(regsFlat)
  );

  assign freqSel = regsFlat[FSEL_W-1:0];
  assign clkEn   = regsFlat[NUM_REGS*8-1:8];

endmodule

// File: tb/test_clkcfg_i2c_slave.sv
module test_clkcfg_i2c_slave;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        scl = 1'b1;
  logic        sdaM = 1'b1;
  logic        sdaOe;
  logic        sdaBus;
  logic [3:0]  freqSel;
  logic [23:0] clkEn;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [7:0] expRegs [4];

  always #5 clk = ~clk;

  assign sdaBus = sdaM & ~sdaOe;

  clkcfg_i2c_slave i_clkcfg_i2c_slave (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (scl),
    .sdaIn  (sdaBus),
    .sdaOe  (sdaOe),
    .freqSel(freqSel),
    .clkEn  (clkEn)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    wt(5); sdaM = 1'b1;
    wt(5); scl = 1'b1;
    wt(5); sdaM = 1'b0;
    wt(5); scl = 1'b0;
  endtask

  task automatic busStop();
    wt(5); sdaM = 1'b0;
    wt(5); scl = 1'b1;
    wt(5); sdaM = 1'b1;
    wt(10);
  endtask

  task automatic sendBits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      wt(5); sdaM = b[i];
      wt(5); scl = 1'b1;
      wt(10); scl = 1'b0;
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    sendBits(b, 8);
    wt(5); sdaM = 1'b1;
    wt(5); scl = 1'b1;
    wt(5); ack = ~sdaBus;
    wt(5); scl = 1'b0;
  endtask

  task automatic readByte(input logic masterAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(10); scl = 1'b1;
      wt(5); b[i] = sdaBus;
      wt(5); scl = 1'b0;
    end
    wt(5); sdaM = ~masterAck;
    wt(5); scl = 1'b1;
    wt(10); scl = 1'b0;
    wt(5); sdaM = 1'b1;
  endtask

  task automatic checkOutputs(input string tag);
    check({"R9 freqSel ", tag}, 32'(freqSel), 32'(expRegs[0][3:0]));
    check({"R9 clkEn ", tag}, 32'(clkEn), 32'({expRegs[3], expRegs[2], expRegs[1]}));
  endtask

  task automatic writeTxn(input logic [7:0] addrB, input int n, input logic [7:0] d [8]);
    logic ack;
    bit   match;
    match = (addrB == 8'hD2);
    busStart();
    sendByte(addrB, ack);
    check(match ? "R2 address ack" : "R2 mismatch no ack", 32'(ack), 32'(match));
    sendByte($urandom_range(0, 255), ack);
    check("R3 command byte ack", 32'(ack), 32'(match));
    sendByte($urandom_range(0, 255), ack);
    check("R3 count byte ack", 32'(ack), 32'(match));
    for (int i = 0; i < n; i++) begin
      sendByte(d[i], ack);
      check(i < 4 ? "R4 data ack" : "R5 extra byte ack", 32'(ack), 32'(match));
      if (match && i < 4) expRegs[i] = d[i];
    end
    busStop();
    checkOutputs(match ? "R4 R5 after write" : "R2 after mismatch");
  endtask

  task automatic readTxn(input int n);
    logic       ack;
    logic [7:0] b;
    busStart();
    sendByte(8'hD3, ack);
    check("R7 read address ack", 32'(ack), 32'd1);
    for (int i = 0; i < n; i++) begin
      readByte(i < n - 1, b);
      check("R7 readback byte", 32'(b), 32'(i < 4 ? expRegs[i] : 8'hFF));
    end
    wt(5);
    check("R7 released after nack", 32'(sdaOe), 32'd0);
    busStop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d [8];
    logic       ack;
    void'($urandom(32'h5EED));
    expRegs[0] = 8'h03;
    expRegs[1] = 8'hFF;
    expRegs[2] = 8'hFF;
    expRegs[3] = 8'hFF;
    wt(5);
    rstN = 1'b1;
    wt(5);

    // R1 reset state
    check("R1 freqSel default", 32'(freqSel), 32'h3);
    check("R1 clkEn default", 32'(clkEn), 32'hFFFFFF);
    check("R1 sdaOe idle", 32'(sdaOe), 32'd0);

    // R4 directed: four registers in order, MSB first
    d = '{8'hA5, 8'h0F, 8'h80, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00};
    writeTxn(8'hD2, 4, d);
    readTxn(4);

    // R5 directed: two bytes beyond the last register
    d = '{8'h3C, 8'hC3, 8'h5A, 8'hA5, 8'h11, 8'h22, 8'h00, 8'h00};
    writeTxn(8'hD2, 6, d);
    readTxn(6);

    // R2 directed: wrong address leaves registers alone
    d = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    writeTxn(8'hD2 ^ 8'h80, 4, d);

    // R6: stop in the middle of a data byte
    busStart();
    sendByte(8'hD2, ack);
    check("R6 address ack", 32'(ack), 32'd1);
    sendByte(8'h00, ack);
    sendByte(8'h00, ack);
    sendBits(8'h00, 4);
    busStop();
    checkOutputs("R6 partial byte dropped");
    // R6: orphan byte after the stop, no start
    wt(5); scl = 1'b0;
    sendByte(8'h00, ack);
    check("R6 orphan byte no ack", 32'(ack), 32'd0);
    wt(5); scl = 1'b1;
    wt(10);
    checkOutputs("R6 orphan byte ignored");

    // R10: repeated start after the command byte
    busStart();
    sendByte(8'hD2, ack);
    sendByte(8'h77, ack);
    busStart();
    sendByte(8'hD2, ack);
    check("R10 address after repeated start", 32'(ack), 32'd1);
    sendByte(8'h99, ack);
    sendByte(8'h99, ack);
    sendByte(8'h46, ack);
    check("R10 data ack", 32'(ack), 32'd1);
    busStop();
    expRegs[0] = 8'h46;
    checkOutputs("R10 stream restarted at register 0");

    // Random mix
    for (int t = 0; t < 14; t++) begin
      int kind;
      kind = $urandom_range(0, 3);
      for (int i = 0; i < 8; i++) d[i] = 8'($urandom_range(0, 255));
      if (kind <= 1) begin
        writeTxn(8'hD2, $urandom_range(0, 6), d);
      end else if (kind == 2) begin
        writeTxn(8'hD2 ^ (8'h1 << $urandom_range(1, 7)), $urandom_range(1, 4), d);
      end else begin
        readTxn($urandom_range(1, 5));
      end
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule